// File: doc/BRIEF.md
# Touch-to-Output Button Controller

This block sits behind four capacitive sense channels and turns their already-qualified touch flags into four active-low output drives, one per channel. Each channel follows its touch flag, keeps its output on for a programmable time after the finger lifts, and forces the output off if a touch lasts longer than a selectable stuck-touch limit. Channels that power-up diagnostics reported as faulty stay silent.

Two optional behaviours change how channels interact. With suppression on, only one channel at a time may own the touch state: the first channel to begin a touch wins, the lowest index breaks a tie, and ownership passes on only once the owner lets go and another channel starts a new touch. With toggle mode on, every fresh touch flips the channel's output, and lifting the finger leaves it as it is. All time is measured in pulses of a one-millisecond tick input.

Top module: `touch_out_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four bits of `drive_n_o` are 1 (inactive).
- R2: A touch on channel i drives `drive_n_o[i]` to 0 within three clock cycles; the other bits of `drive_n_o` are unaffected.
- R3: After channel i is released, `drive_n_o[i]` stays 0 for `cfg_hold_ms` tick pulses and then returns to 1; with a hold of 0 it returns to 1 within three cycles of the release.
- R4: A hold value above 2000 behaves exactly like a hold of 2000.
- R5: A touch held without a break turns its output off after the auto-reset period: 5000 tick pulses when `cfg_long_ar` is 0, 20000 when it is 1.
- R6: After an auto-reset the output stays off for as long as the touch is held; only after the touch flag has been 0 can a new touch activate the channel again.
- R7: A channel whose `fault_i` bit is 1 never drives its output to 0, whatever its touch flag does.
- R8: With `cfg_suppress` at 1, while one channel owns the touch state, touches that begin on other channels leave their outputs at 1.
- R9: With `cfg_suppress` at 1, when several channels begin a touch in the same cycle, the lowest-numbered one becomes the owner.
- R10: Ownership ends when the owner's touch flag falls; a channel that was already being touched at that point does not take over until its touch is released and begins again.
- R11: With `cfg_toggle` at 1, each new touch on channel i inverts `drive_n_o[i]`; releasing the touch leaves it unchanged and no hold time applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond; all timers count it |
| touch_i | input | 4 | Qualified touch flag per channel, 1 = touched |
| fault_i | input | 4 | Diagnostic disable per channel, 1 = faulty |
| cfg_toggle | input | 1 | 1 = toggle mode |
| cfg_suppress | input | 1 | 1 = single-owner suppression across channels |
| cfg_long_ar | input | 1 | Auto-reset period: 0 = 5000 ticks, 1 = 20000 ticks |
| cfg_hold_ms | input | 12 | Post-release hold in ticks, values above 2000 clamp to 2000 |
| drive_n_o | output | 4 | Registered output drive per channel, 0 = active |

## Verification
The hardest condition to reach is the hand-over of suppression ownership: a second channel must be touched while the first still owns the state, and the owner must then be released while the second is still held, so that the bench can show the second stays dark until it is released and touched again. The stimulus builds this by layering touches in a fixed order on one channel pair, then repeating the fresh touch. The auto-reset periods are reached by giving the bench instance short period parameters and holding the tick input high, so each clock counts as one millisecond, while the 2000 clamp is exercised at its real size.

// File: rtl/touch_out_pkg.sv
package touch_out_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_ACT  = 2'd1,
    CH_HOLD = 2'd2,
    CH_LOCK = 2'd3
  } ch_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/toc_timing_cfg.sv
// Turns static configuration into the two timer limits used by every channel.
module toc_timing_cfg #(
  parameter int HOLD_W   = 12,
  parameter int HOLD_MAX = 2000,
  parameter int SHORT_MS = 5000,
  parameter int LONG_MS  = 20000,
  parameter int CNT_W    = 15
) (
  input  logic [HOLD_W-1:0] hold_ms,
  input  logic              long_sel,
  output logic [CNT_W-1:0]  hold_lim,
  output logic [CNT_W-1:0]  ar_lim
);

  localparam logic [HOLD_W-1:0] HOLD_CAP = HOLD_W'(HOLD_MAX);

  always_comb begin
    if (hold_ms > HOLD_CAP) hold_lim = CNT_W'(HOLD_MAX);
    else                    hold_lim = CNT_W'(hold_ms);
  end

  always_comb begin
    if (long_sel) ar_lim = CNT_W'(LONG_MS);
    else          ar_lim = CNT_W'(SHORT_MS);
  end

endmodule

// File: rtl/toc_owner_arb.sv
// Single-owner arbitration: a fresh touch onset claims ownership when free,
// the lowest index wins a tie, the owner keeps it until its touch ends.
module toc_owner_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     grant,
  output logic             own_v,
  output logic [IDX_W-1:0] own_idx
);

  logic [N-1:0]     cand_q;
  logic [N-1:0]     rise;
  logic [IDX_W-1:0] pick;
  logic             found;

  assign rise = cand & ~cand_q;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (rise[i] && !found) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q  <= '0;
      own_v   <= 1'b0;
      own_idx <= '0;
    end else begin
      cand_q <= cand;
      if (!en) begin
        own_v <= 1'b0;
      end else if (own_v) begin
        if (!cand[own_idx]) own_v <= 1'b0;
      end else if (found) begin
        own_v   <= 1'b1;
        own_idx <= pick;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i] = own_v && (own_idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/toc_channel.sv
// One channel: follow / hold / auto-reset lock / toggle latch.
module toc_channel
  import touch_out_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             touch_raw,
  input  logic             eff_touch,
  input  logic             fault,
  input  logic             toggle_en,
  input  logic [CNT_W-1:0] ar_lim,
  input  logic [CNT_W-1:0] hold_lim,
  output logic             on_o,
  output logic             active_o,
  output logic             lock_o
);

  ch_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             tog, tog_n;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    tog_n = tog;
    if (fault) begin
      st_n  = CH_IDLE;
      cnt_n = '0;
      tog_n = 1'b0;
    end else begin
      case (st)
        CH_IDLE: begin
          if (eff_touch) begin
            st_n  = CH_ACT;
            cnt_n = '0;
            if (toggle_en) tog_n = ~tog;
          end
        end
        CH_ACT: begin
          if (!eff_touch) begin
            cnt_n = '0;
            if (toggle_en || hold_lim == '0) st_n = CH_IDLE;
            else                             st_n = CH_HOLD;
          end else if (tick) begin
            if (cnt_inc >= ar_lim) begin
              st_n  = CH_LOCK;
              cnt_n = '0;
              tog_n = 1'b0;
            end else begin
              cnt_n = cnt_inc;
            end
          end
        end
        CH_HOLD: begin
          if (eff_touch) begin
            st_n  = CH_ACT;
            cnt_n = '0;
          end else if (tick) begin
            if (cnt_inc >= hold_lim) begin
              st_n  = CH_IDLE;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_inc;
            end
          end
        end
        default: begin
          if (!touch_raw) st_n = CH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CH_IDLE;
      cnt <= '0;
      tog <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      tog <= tog_n;
    end
  end

  assign on_o     = toggle_en ? tog : (st == CH_ACT || st == CH_HOLD);
  assign active_o = (st == CH_ACT);
  assign lock_o   = (st == CH_LOCK);

endmodule

// File: rtl/touch_out_ctrl.sv
module touch_out_ctrl
  import touch_out_pkg::*;
#(
  parameter int N        = 4,
  parameter int HOLD_W   = 12,
  parameter int HOLD_MAX = 2000,
  parameter int SHORT_MS = 5000,
  parameter int LONG_MS  = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic [N-1:0]      touch_i,
  input  logic [N-1:0]      fault_i,
  input  logic              cfg_toggle,
  input  logic              cfg_suppress,
  input  logic              cfg_long_ar,
  input  logic [HOLD_W-1:0] cfg_hold_ms,
  output logic [N-1:0]      drive_n_o
);

  localparam int TOP_MS = max3(HOLD_MAX, SHORT_MS, LONG_MS);
  localparam int CNT_W  = $clog2(TOP_MS + 1);
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     cand;
  logic [N-1:0]     grant;
  logic [N-1:0]     eff;
  logic [N-1:0]     on_vec;
  logic [N-1:0]     active_vec;
  logic [N-1:0]     lock_vec;
  logic             own_v;
  logic [IDX_W-1:0] own_idx;
  logic [CNT_W-1:0] hold_lim;
  logic [CNT_W-1:0] ar_lim;
  logic [N-1:0]     drive_q;

  assign cand = touch_i & ~fault_i;
  assign eff  = cfg_suppress ? (cand & grant) : cand;

  toc_timing_cfg #(
    .HOLD_W  (HOLD_W),
    .HOLD_MAX(HOLD_MAX),
    .SHORT_MS(SHORT_MS),
    .LONG_MS (LONG_MS),
    .CNT_W   (CNT_W)
  ) u_cfg (
    .hold_ms (cfg_hold_ms),
    .long_sel(cfg_long_ar),
    .hold_lim(hold_lim),
    .ar_lim  (ar_lim)
  );

  toc_owner_arb #(
    .N    (N),
    .IDX_W(IDX_W)
  ) u_arb (
    .clk    (clk),
    .rst    (rst),
    .en     (cfg_suppress),
    .cand   (cand),
    .grant  (grant),
    .own_v  (own_v),
    .own_idx(own_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_ch
    toc_channel #(
      .CNT_W(CNT_W)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_ms),
      .touch_raw(touch_i[g]),
      .eff_touch(eff[g]),
      .fault    (fault_i[g]),
      .toggle_en(cfg_toggle),
      .ar_lim   (ar_lim),
      .hold_lim (hold_lim),
      .on_o     (on_vec[g]),
      .active_o (active_vec[g]),
      .lock_o   (lock_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= '1;
    else     drive_q <= ~on_vec;
  end

  assign drive_n_o = drive_q;

endmodule

// File: rtl/touch_out_ctrl_chk.sv
module touch_out_ctrl_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     touch_i,
  input logic [N-1:0]     fault_i,
  input logic             cfg_suppress,
  input logic [N-1:0]     drive_n_o,
  input logic [N-1:0]     active_vec,
  input logic [N-1:0]     lock_vec,
  input logic             own_v,
  input logic [IDX_W-1:0] own_idx
);

  // R1: outputs inactive on the first cycle out of reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (drive_n_o == '1));

  // R7: a channel faulty two cycles back cannot be driving now
  p_fault_silent_r7: assert property (@(posedge clk) disable iff (rst)
    ((~drive_n_o & $past(fault_i, 2)) == '0));

  // R8: with suppression held on, at most one channel is in the touch state
  p_single_active_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_suppress && $past(cfg_suppress)) |-> ($countones(active_vec) <= 1));

  // R10: owner is kept while its touch continues
  p_owner_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_suppress && own_v && touch_i[own_idx] && !fault_i[own_idx])
      |=> (!cfg_suppress || (own_v && $stable(own_idx))));

  // R6: a locked channel leaves the lock only after its touch flag was low
  p_lock_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_vec) & ~lock_vec & $past(touch_i) & ~$past(fault_i)) == '0));

endmodule

bind touch_out_ctrl touch_out_ctrl_chk #(
  .N    (N),
  .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .touch_i     (touch_i),
  .fault_i     (fault_i),
  .cfg_suppress(cfg_suppress),
  .drive_n_o   (drive_n_o),
  .active_vec  (active_vec),
  .lock_vec    (lock_vec),
  .own_v       (own_v),
  .own_idx     (own_idx)
);

// File: tb/sim_touch_out_ctrl.sv
`timescale 1ns/1ps
module sim_touch_out_ctrl;

  localparam int SHORT_T = 100;
  localparam int LONG_T  = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_ms = 1'b1;
  logic [3:0]  touch_i = '0;
  logic [3:0]  fault_i = '0;
  logic        cfg_toggle = 1'b0;
  logic        cfg_suppress = 1'b0;
  logic        cfg_long_ar = 1'b0;
  logic [11:0] cfg_hold_ms = '0;
  logic [3:0]  drive_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  touch_out_ctrl #(
    .N(4), .HOLD_W(12), .HOLD_MAX(2000), .SHORT_MS(SHORT_T), .LONG_MS(LONG_T)
  ) u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .touch_i(touch_i), .fault_i(fault_i),
    .cfg_toggle(cfg_toggle), .cfg_suppress(cfg_suppress), .cfg_long_ar(cfg_long_ar),
    .cfg_hold_ms(cfg_hold_ms), .drive_n_o(drive_n_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if (drive_n_o !== exp) begin
      errors++;
      $display("FAIL %s drive_n_o actual=%b expected=%b", req, drive_n_o, exp);
    end
  endtask

  task automatic idle_all();
    touch_i = '0; fault_i = '0; cfg_toggle = 1'b0; cfg_suppress = 1'b0;
    cfg_long_ar = 1'b0; cfg_hold_ms = '0;
    cyc(6);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; cyc(3);
    chk(4'b1111, "R1 in reset");
    rst = 1'b0; cyc(1);
    chk(4'b1111, "R1 after reset");
  endtask

  task automatic t_follow_r2();
    touch_i = 4'b0010; cyc(3);
    chk(4'b1101, "R2 channel 1 active");
    touch_i = 4'b1010; cyc(3);
    chk(4'b0101, "R2 channels 1 and 3 active");
    idle_all();
    chk(4'b1111, "R2 released");
  endtask

  task automatic t_hold_r3();
    cfg_hold_ms = 12'd20;
    touch_i = 4'b0001; cyc(5);
    touch_i = 4'b0000; cyc(10);
    chk(4'b1110, "R3 inside hold");
    cyc(20);
    chk(4'b1111, "R3 hold expired");
    cfg_hold_ms = 12'd0;
    touch_i = 4'b0100; cyc(5);
    touch_i = 4'b0000; cyc(3);
    chk(4'b1111, "R3 zero hold");
    idle_all();
  endtask

  task automatic t_clamp_r4();
    cfg_hold_ms = 12'd4000;
    touch_i = 4'b1000; cyc(5);
    touch_i = 4'b0000; cyc(1990);
    chk(4'b0111, "R4 still held near 2000");
    cyc(20);
    chk(4'b1111, "R4 clamped to 2000");
    idle_all();
  endtask

  task automatic t_autoreset_r5_r6();
    cfg_hold_ms = 12'd0;
    touch_i = 4'b0001; cyc(SHORT_T - 10);
    chk(4'b1110, "R5 before short period");
    cyc(20);
    chk(4'b1111, "R5 short period reset");
    cyc(50);
    chk(4'b1111, "R6 locked while held");
    touch_i = 4'b0000; cyc(3);
    touch_i = 4'b0001; cyc(3);
    chk(4'b1110, "R6 reactivates after release");
    touch_i = 4'b0000; cyc(5);
    cfg_long_ar = 1'b1;
    touch_i = 4'b0010; cyc(LONG_T - 10);
    chk(4'b1101, "R5 before long period");
    cyc(20);
    chk(4'b1111, "R5 long period reset");
    idle_all();
  endtask

  task automatic t_fault_r7();
    fault_i = 4'b0100;
    touch_i = 4'b1100; cyc(5);
    chk(4'b0111, "R7 faulty channel 2 silent");
    touch_i = 4'b0100; cyc(5);
    chk(4'b1111, "R7 faulty channel alone");
    idle_all();
  endtask

  task automatic t_suppress_r8();
    cfg_suppress = 1'b1; cyc(2);
    touch_i = 4'b0010; cyc(5);
    chk(4'b1101, "R8 first owner");
    touch_i = 4'b0111; cyc(5);
    chk(4'b1101, "R8 later touches suppressed");
    idle_all();
  endtask

  task automatic t_tie_r9();
    cfg_suppress = 1'b1; cyc(2);
    touch_i = 4'b1100; cyc(5);
    chk(4'b1011, "R9 lowest index wins tie");
    idle_all();
  endtask

  task automatic t_handover_r10();
    cfg_suppress = 1'b1; cyc(2);
    touch_i = 4'b0001; cyc(5);
    touch_i = 4'b0011; cyc(5);
    touch_i = 4'b0010; cyc(5);
    chk(4'b1111, "R10 held channel does not take over");
    touch_i = 4'b0000; cyc(3);
    touch_i = 4'b0010; cyc(5);
    chk(4'b1101, "R10 fresh touch takes ownership");
    idle_all();
  endtask

  task automatic t_toggle_r11();
    cfg_toggle = 1'b1; cfg_hold_ms = 12'd20; cyc(2);
    touch_i = 4'b1000; cyc(5);
    chk(4'b0111, "R11 first touch on");
    touch_i = 4'b0000; cyc(5);
    chk(4'b0111, "R11 release keeps on");
    touch_i = 4'b1000; cyc(5);
    chk(4'b1111, "R11 second touch off");
    touch_i = 4'b0000; cyc(3);
    chk(4'b1111, "R11 no hold after release");
    idle_all();
  endtask

  initial begin
    cyc(2);
    t_reset_r1();
    idle_all();
    t_follow_r2();
    t_hold_r3();
    t_clamp_r4();
    t_autoreset_r5_r6();
    t_fault_r7();
    t_suppress_r8();
    t_tie_r9();
    t_handover_r10();
    t_toggle_r11();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule